// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the control logic of a 16-bit-wide parallel NOR flash device, for use in the chip's model of an external memory. It samples the active-low chip enable, output enable and write enable pins against the system clock. From those pins it classifies each bus cycle as a read, a write or standby, follows a six-write unlock-and-command sequence that requests a whole-array erase, and runs that erase as a timed internal operation. The array is a small register-backed memory.

While the erase runs, a read returns a status word instead of array data. Bit 7 holds the complement of the final data and so reads 0. Bit 6 changes from one read to the next. Writes that arrive during the erase are discarded. After a set number of clock cycles, every bit of the array holds 1 and reads return data again. Writes carry only command bytes, because word programming is not part of this block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A read cycle (ce_n=0, oe_n=0, we_n=1) raises dq_oe and drives the word at address bits [IDX_W-1:0] onto dq_out. After reset, word i holds A500h + i.
- R2: While ce_n is high, dq_oe stays low whatever oe_n and we_n are doing.
- R3: A cycle with ce_n low and oe_n low and we_n low is inhibited. It is neither a write nor a read, and it leaves the command tracker where it was.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h, made in that order, start the erase when the sixth write cycle ends, whichever of we_n or ce_n rises first. Only the low byte of the data and the full address are compared.
- R5: A write that does not match the next expected step returns the tracker to idle, and no erase starts.
- R6: During the erase, a read drives a status word in which bit 7 is 0 and every bit other than bit 6 is 0.
- R7: Status bit 6 is 0 on the first read of an erase and inverts after each completed read while the erase lasts.
- R8: Writes made while the erase runs are ignored, and the tracker stays idle.
- R9: The erase stays busy for exactly ERASE_CYCLES clock cycles. After that, every word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 8 | Command byte carried by a write |
| dq_out | output | DATA_W | Read data or erase status |
| dq_oe | output | 1 | High while the device drives the data bus |

## Verification
Reads at random addresses are mixed with random writes that match no step, so that array contents and the tracker's return to idle are seen together. Several sequences are run on purpose: a complete one, one with a wrong sixth write, a lone final step, and one whose sixth write is first made as an inhibited cycle. Between them, these separate a tracker that counts writes from one that checks address and data. They also separate a tracker that treats inhibited cycles as writes from one that does not. During the erase, three reads in a row tell a toggling status bit apart from a fixed one. Command writes made during the erase, followed by a lone final step after it, show whether busy-time writes moved the tracker.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and helpers for the flash command interpreter.
// Assumes the command addresses fit in 15 bits and commands are bytes.
package flash_cmd_pkg;
    localparam int CMD_ADDR_W = 15;
    localparam int STEP_W     = 3;
    localparam logic [STEP_W-1:0] LAST_STEP = 3'd5;

    // Address expected at each step of the erase sequence.
    function automatic logic [CMD_ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] s);
        case (s)
            3'd1, 3'd4: step_addr = 15'h2AAA;
            default:    step_addr = 15'h5555;
        endcase
    endfunction

    // Command byte expected at each step of the erase sequence.
    function automatic logic [7:0] step_byte(input logic [STEP_W-1:0] s);
        case (s)
            3'd0, 3'd3: step_byte = 8'hAA;
            3'd1, 3'd4: step_byte = 8'h55;
            3'd2:       step_byte = 8'h80;
            default:    step_byte = 8'h10;
        endcase
    endfunction
endpackage

// File: rtl/flash_sync.sv
// Two-flop synchroniser for a bundle of pins.
// Assumes multi-bit buses are held stable around strobe edges.
module flash_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Pass the pins through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/flash_seq_tracker.sv
// Follows the six-write erase command sequence.
// A write that does not match sends it back to idle. It ignores writes while busy.
// The start signal is combinational so that the erase begins on the strobe-end cycle.
module flash_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              start
);
    logic hit;

    // Compare the finished write with the expected step and flag the final one.
    always_comb begin
        hit   = (wr_addr == ADDR_W'(step_addr(step))) && (wr_byte == step_byte(step));
        start = wr_end && !busy && hit && (step == LAST_STEP);
    end

    // Advance on a match, fall back to idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (wr_end && !busy) begin
            step <= (hit && step != LAST_STEP) ? step + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/flash_erase_timer.sv
// Busy timer for the internal erase.
// It holds busy for CYCLES clocks after start and pulses done on the last one.
// Assumes start never arrives while busy.
module flash_erase_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    // Flag the final busy cycle.
    assign done = busy && (cnt == CNT_W'(CYCLES - 1));

    // Count busy cycles from start to done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Control logic of a 16-bit parallel NOR flash.
// It decodes bus cycles, tracks the erase command sequence, times the erase and reads back status.
// Assumes DEPTH is a power of two and the pins change slowly against clk.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 16,
    parameter int DEPTH        = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              ce_s, oe_s, we_s;
    logic [ADDR_W-1:0] addr_s, cmd_addr;
    logic [7:0]        din_s, cmd_byte;
    logic              wr_act, rd_act, wr_q, rd_q, wr_end, rd_end;
    logic              start, busy, done, tog;
    logic [STEP_W-1:0] step;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH*DATA_W-1:0] mem_flat;

    flash_sync #(.W(3), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q({ce_s, oe_s, we_s})
    );

    flash_sync #(.W(ADDR_W + 8)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q({addr_s, din_s})
    );

    // Classify the synchronised bus cycle.
    assign wr_act = !ce_s && oe_s && !we_s;
    assign rd_act = !ce_s && !oe_s && we_s;
    assign wr_end = wr_q && !wr_act;
    assign rd_end = rd_q && !rd_act;

    // Remember cycle activity and latch address and command while writing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            cmd_addr <= '0;
            cmd_byte <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act) begin
                cmd_addr <= addr_s;
                cmd_byte <= din_s;
            end
        end
    end

    flash_seq_tracker #(.ADDR_W(ADDR_W)) u_tracker (
        .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_addr(cmd_addr),
        .wr_byte(cmd_byte), .busy(busy), .step(step), .start(start)
    );

    flash_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    // Load the reset pattern, or set every bit when the erase finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(16'hA500 + i);
        end else if (done) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end
    end

    // Toggle bit: cleared at erase start, inverted after each read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog <= 1'b0;
        else if (start)          tog <= 1'b0;
        else if (busy && rd_end) tog <= ~tog;
    end

    // Status word: the data-complement bit reads 0, bit 6 carries the toggle.
    always_comb begin
        status    = '0;
        status[6] = tog;
    end

    // Drive array data or status during a read, nothing otherwise.
    assign dq_oe  = rd_act;
    assign dq_out = !rd_act ? '0 : (busy ? status : mem[addr_s[IDX_W-1:0]]);

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign mem_flat[g*DATA_W +: DATA_W] = mem[g];
    end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Checker for flash_cmd_ctrl, attached by bind. It watches the pins and internal state.
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int DEPTH        = 16,
    parameter int ERASE_CYCLES = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ce_n,
    input logic                    oe_n,
    input logic                    dq_oe,
    input logic [DATA_W-1:0]       dq_out,
    input logic                    busy,
    input logic [STEP_W-1:0]       step,
    input logic [DEPTH*DATA_W-1:0] mem_flat
);
    int busy_len;

    // Count the length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R2
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2)));
    // R6
    status_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out[7] == 1'b0));
    // R4
    start_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(step) == LAST_STEP));
    // R8
    idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step == '0));
    // R9
    erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == ERASE_CYCLES));
    // R9
    erased_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&mem_flat));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq_oe(dq_oe),
    .dq_out(dq_out), .busy(busy), .step(step), .mem_flat(mem_flat)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int ECYC   = 120;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;
    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] rv;
    logic              ro;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .ERASE_CYCLES(ECYC)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] init_word(input int i);
        return DATA_W'(16'hA500 + (i % DEPTH));
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic w,
                         input logic [ADDR_W-1:0] a, input logic [7:0] d);
        ce_n = c; oe_n = o; we_n = w; addr = a; dq_in = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive(1, 1, 1, '0, '0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        drive(0, 1, 0, a, d);
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a,
                            output logic [DATA_W-1:0] v, output logic o);
        @(negedge clk);
        drive(0, 0, 1, a, '0);
        repeat (5) @(negedge clk);
        v = dq_out;
        o = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic first_five();
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h80);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        check("R2 reset idle oe", 32'(dq_oe), 32'd0);

        // R2: standby with OE low
        @(negedge clk);
        drive(1, 0, 1, 15'h0003, '0);
        repeat (5) @(negedge clk);
        check("R2 standby oe", 32'(dq_oe), 32'd0);
        drive(1, 1, 0, 15'h0003, '0);
        repeat (5) @(negedge clk);
        check("R2 standby oe we low", 32'(dq_oe), 32'd0);
        drive(1, 1, 1, '0, '0);

        // R1 and R5: random reads mixed with stray writes
        for (int k = 0; k < 40; k++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            if ($urandom % 3 == 0)
                bus_write(ADDR_W'(15'h1000 + ($urandom % 256)), 8'($urandom));
            bus_read(a, rv, ro);
            check("R1 read oe", 32'(ro), 32'd1);
            check("R1 read data", 32'(rv), 32'(init_word(int'(a))));
        end

        // R5: wrong final write, then a lone final step
        first_five();
        bus_write(15'h1234, 8'h10);
        bus_read(15'h0005, rv, ro);
        check("R5 broken sixth", 32'(rv), 32'(init_word(5)));
        bus_write(15'h5555, 8'h10);
        bus_read(15'h0006, rv, ro);
        check("R5 lone last step", 32'(rv), 32'(init_word(6)));
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h5555, 8'h80);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h10);
        bus_read(15'h0007, rv, ro);
        check("R5 wrong second step", 32'(rv), 32'(init_word(7)));

        // R3: inhibited sixth write, then the real one (R4)
        do_reset();
        first_five();
        @(negedge clk);
        drive(0, 0, 0, 15'h5555, 8'h10);
        repeat (5) @(negedge clk);
        check("R3 inhibited oe", 32'(dq_oe), 32'd0);
        drive(1, 1, 1, 15'h5555, 8'h10);
        repeat (4) @(negedge clk);
        bus_read(15'h0002, rv, ro);
        check("R3 no erase after inhibit", 32'(rv), 32'(init_word(2)));
        bus_write(15'h5555, 8'h10);

        // R4, R6, R7: status reads while busy
        bus_read(15'h0002, rv, ro);
        check("R4 erase started", 32'(ro), 32'd1);
        check("R6 R7 status read 1", 32'(rv), 32'h0000);
        bus_read(15'h0004, rv, ro);
        check("R7 status read 2", 32'(rv), 32'h0040);
        bus_read(15'h0009, rv, ro);
        check("R6 R7 status read 3", 32'(rv), 32'h0000);

        // R8: a sequence written while busy must be discarded
        first_five();
        repeat (200) @(negedge clk);
        bus_write(15'h5555, 8'h10);
        bus_read(15'h0001, rv, ro);
        check("R8 busy writes ignored", 32'(rv), 32'hFFFF);

        // R9: whole array reads ones
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(ADDR_W'(i), rv, ro);
            check("R9 erased word", 32'(rv), 32'hFFFF);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule